// File: doc/BRIEF.md
# Vector Length Control Register

This block holds the active vector length for a vector-capable issue stage and hands it to downstream issue logic. Two kinds of request can change the length. A length-setting request carries the loop's requested element count and a compile-time ceiling. The ceiling arrives as an immediate, so no register holds a maximum length. A direct control-register write carries a new length either from a full-width register operand or from a small unsigned immediate.

The two paths treat zero in opposite ways. A length-setting request may produce a length of zero, so a loop can branch on its result after the request has issued. A control-register write of zero is taken to mean the hardware maximum. Alongside the length, the block exports a flag that permits predicated instructions only while the length fits in one integer register.

Top module: `vlen_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `vl` to 1 and `pred_allowed` to 1.
- R2: A length-setting request sets the length to the smaller of `setvl_count` and the ceiling. The ceiling is `setvl_maxvl_imm` clamped to the hardware maximum of 64. A count of zero gives a length of zero.
- R3: `setvl_result` shows, in the same cycle as the request and with no register in the path, the value that request will load.
- R4: A register-form control write (`csr_wr_imm_sel` = 0) loads `csr_wr_data`. A value of zero loads 64, and any value above 64 loads 64.
- R5: An immediate-form control write (`csr_wr_imm_sel` = 1) loads the 5-bit `csr_wr_uimm` zero-extended, so it covers 1 to 31. An immediate of zero loads 64.
- R6: `pred_allowed` is 1 exactly when the stored length is at most the parameter `XLEN`. It changes on the same edge as `vl`.
- R7: When a length-setting request and a control write arrive in the same cycle, the length-setting request wins and the control write is dropped.
- R8: With no request active, `vl` and `pred_allowed` keep their values.
- R9: A new length appears on `vl` one cycle after its request and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setvl_req | input | 1 | Length-setting request valid |
| setvl_count | input | DATA_W | Requested element count |
| setvl_maxvl_imm | input | VL_W | Compile-time length ceiling |
| csr_wr_en | input | 1 | Direct control-register write valid |
| csr_wr_imm_sel | input | 1 | 1 selects the immediate form, 0 the register form |
| csr_wr_data | input | DATA_W | Register-form write value |
| csr_wr_uimm | input | UIMM_W | Immediate-form write value |
| vl | output | VL_W | Current vector length |
| pred_allowed | output | 1 | Predicated instructions permitted |
| setvl_result | output | VL_W | Length the current length-setting request yields |

## Verification
The bench goes after the two opposite meanings of zero. If the zero-to-maximum rule were applied to the length-setting path, a zero count would read back as 64 and not 0. If the rule were missing from either control-write form, the stored length would be 0. Ceilings above 64 and register writes far above 64 are checked to clamp to exactly 64, because a plain truncation to seven bits would wrap them to a small length. With `XLEN` overridden to 32, lengths of 32 and 33 probe the predication boundary, where an off-by-one comparison would flip the flag. A collision between both request kinds exposes a design with the priority reversed, since it would load the control-write value.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    localparam int unsigned HW_MAX_VL = 64;
    localparam int unsigned VL_W      = $clog2(HW_MAX_VL + 1);

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SETVL = 2'd1,
        SRC_CSR   = 2'd2
    } upd_src_e;

    typedef struct packed {
        upd_src_e          src;
        logic [VL_W-1:0]   value;
    } vl_upd_t;

    function automatic logic [VL_W-1:0] clamp_ceiling(input logic [VL_W-1:0] imm);
        if (imm > VL_W'(HW_MAX_VL))
            return VL_W'(HW_MAX_VL);
        return imm;
    endfunction

endpackage

// File: rtl/vlen_setvl_calc.sv
module vlen_setvl_calc
    import vlen_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] count,
    input  logic [VL_W-1:0]   maxvl_imm,
    output logic [VL_W-1:0]   result
);
    logic [VL_W-1:0] ceiling;

    always_comb begin
        ceiling = clamp_ceiling(maxvl_imm);
        if (count > DATA_W'(ceiling))
            result = ceiling;
        else
            result = count[VL_W-1:0];
    end
endmodule

// File: rtl/vlen_csr_calc.sv
module vlen_csr_calc
    import vlen_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned UIMM_W = 5
) (
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] data,
    input  logic [UIMM_W-1:0] uimm,
    output logic [VL_W-1:0]   value
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        raw = imm_sel ? {{(DATA_W-UIMM_W){1'b0}}, uimm} : data;
        if (raw == '0)
            value = VL_W'(HW_MAX_VL);
        else if (raw > DATA_W'(HW_MAX_VL))
            value = VL_W'(HW_MAX_VL);
        else
            value = raw[VL_W-1:0];
    end
endmodule

// File: rtl/vlen_state.sv
module vlen_state
    import vlen_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  vl_upd_t         upd,
    output logic [VL_W-1:0] vl_q,
    output logic            pred_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q   <= VL_W'(1);
            pred_q <= 1'b1;
        end else if (upd.src != SRC_NONE) begin
            vl_q   <= upd.value;
            pred_q <= ({{(32-VL_W){1'b0}}, upd.value} <= 32'(XLEN));
        end
    end
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
    import vlen_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned UIMM_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setvl_req,
    input  logic [DATA_W-1:0] setvl_count,
    input  logic [VL_W-1:0]   setvl_maxvl_imm,
    input  logic              csr_wr_en,
    input  logic              csr_wr_imm_sel,
    input  logic [DATA_W-1:0] csr_wr_data,
    input  logic [UIMM_W-1:0] csr_wr_uimm,
    output logic [VL_W-1:0]   vl,
    output logic              pred_allowed,
    output logic [VL_W-1:0]   setvl_result
);
    logic [VL_W-1:0] setvl_val;
    logic [VL_W-1:0] csr_val;
    vl_upd_t         upd;

    vlen_setvl_calc #(.DATA_W(DATA_W)) setvl_calc_i (
        .count     (setvl_count),
        .maxvl_imm (setvl_maxvl_imm),
        .result    (setvl_val)
    );

    vlen_csr_calc #(.DATA_W(DATA_W), .UIMM_W(UIMM_W)) csr_calc_i (
        .imm_sel (csr_wr_imm_sel),
        .data    (csr_wr_data),
        .uimm    (csr_wr_uimm),
        .value   (csr_val)
    );

    always_comb begin
        if (setvl_req) begin
            upd.src   = SRC_SETVL;
            upd.value = setvl_val;
        end else if (csr_wr_en) begin
            upd.src   = SRC_CSR;
            upd.value = csr_val;
        end else begin
            upd.src   = SRC_NONE;
            upd.value = '0;
        end
    end

    vlen_state #(.XLEN(XLEN)) state_i (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .vl_q   (vl),
        .pred_q (pred_allowed)
    );

    assign setvl_result = setvl_val;
endmodule

// File: rtl/vlen_ctrl_chk.sv
module vlen_ctrl_chk
    import vlen_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              setvl_req,
    input logic [DATA_W-1:0] setvl_count,
    input logic              csr_wr_en,
    input logic [VL_W-1:0]   vl,
    input logic              pred_allowed,
    input logic [VL_W-1:0]   setvl_result
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!setvl_req && !csr_wr_en) |=> ($stable(vl) && $stable(pred_allowed))); // R8

    AST_SETVL_LOADS_RESULT: assert property (@(posedge clk) disable iff (rst)
        setvl_req |=> (vl == $past(setvl_result))); // R3

    AST_SETVL_NOT_ABOVE_COUNT: assert property (@(posedge clk) disable iff (rst)
        setvl_req |=> (DATA_W'(vl) <= $past(setvl_count))); // R2

    AST_CSR_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && !setvl_req) |=> (vl != '0)); // R4

    AST_VL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        vl <= VL_W'(HW_MAX_VL)); // R5

    AST_PRED_MATCHES_VL: assert property (@(posedge clk) disable iff (rst)
        pred_allowed == ({{(32-VL_W){1'b0}}, vl} <= 32'(XLEN))); // R6
endmodule

bind vlen_ctrl vlen_ctrl_chk #(.XLEN(XLEN), .DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .setvl_req    (setvl_req),
    .setvl_count  (setvl_count),
    .csr_wr_en    (csr_wr_en),
    .vl           (vl),
    .pred_allowed (pred_allowed),
    .setvl_result (setvl_result)
);

// File: tb/vlen_ctrl_tb_top.sv
module vlen_ctrl_tb_top;
    import vlen_pkg::*;

    localparam int unsigned XLEN_T = 32;
    localparam int unsigned DW     = 64;
    localparam int unsigned UW     = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          setvl_req = 1'b0;
    logic [DW-1:0] setvl_count = '0;
    logic [VL_W-1:0] setvl_maxvl_imm = '0;
    logic          csr_wr_en = 1'b0;
    logic          csr_wr_imm_sel = 1'b0;
    logic [DW-1:0] csr_wr_data = '0;
    logic [UW-1:0] csr_wr_uimm = '0;
    logic [VL_W-1:0] vl;
    logic          pred_allowed;
    logic [VL_W-1:0] setvl_result;

    always #5 clk = ~clk;

    vlen_ctrl #(.XLEN(XLEN_T), .DATA_W(DW), .UIMM_W(UW)) dut_i (
        .clk(clk), .rst(rst),
        .setvl_req(setvl_req), .setvl_count(setvl_count), .setvl_maxvl_imm(setvl_maxvl_imm),
        .csr_wr_en(csr_wr_en), .csr_wr_imm_sel(csr_wr_imm_sel),
        .csr_wr_data(csr_wr_data), .csr_wr_uimm(csr_wr_uimm),
        .vl(vl), .pred_allowed(pred_allowed), .setvl_result(setvl_result)
    );

    typedef struct {
        int    vl;
        bit    pred;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    model_vl = 1;
    bit    done     = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_setvl(input longint unsigned cnt, input int imm);
        int ceil_v;
        ceil_v = (imm > 64) ? 64 : imm;
        return (cnt > longint'(ceil_v)) ? ceil_v : int'(cnt);
    endfunction

    function automatic int exp_csr(input bit sel, input longint unsigned data, input int u);
        longint unsigned raw;
        raw = sel ? longint'(u) : data;
        if (raw == 0 || raw > 64) return 64;
        return int'(raw);
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic step(input bit sv, input longint unsigned cnt, input int imm,
                        input bit cw, input bit sel, input longint unsigned data,
                        input int u, input string tag);
        exp_t e;
        int   prev;
        @(negedge clk);
        prev            = model_vl;
        setvl_req       = sv;
        setvl_count     = cnt;
        setvl_maxvl_imm = VL_W'(imm);
        csr_wr_en       = cw;
        csr_wr_imm_sel  = sel;
        csr_wr_data     = data;
        csr_wr_uimm     = UW'(u);
        if (sv) model_vl = exp_setvl(cnt, imm);
        else if (cw) model_vl = exp_csr(sel, data, u);
        e.vl   = model_vl;
        e.pred = (model_vl <= XLEN_T);
        e.tag  = tag;
        sb_q.push_back(e);
        #1;
        if (sv) check({tag, " R3 result"}, int'(setvl_result), model_vl);
        check({tag, " R9 no early update"}, int'(vl), prev);
    endtask

    // Monitor: compares registered outputs after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " vl"}, int'(vl), e.vl);
                check({e.tag, " R6 pred"}, int'(pred_allowed), int'(e.pred));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset vl", int'(vl), 1);
        check("R1 reset pred", int'(pred_allowed), 1);

        step(1, 10,  16, 0, 0, 0, 0, "R2 count below ceiling");
        step(1, 100, 16, 0, 0, 0, 0, "R2 count above ceiling");
        step(1, 0,   16, 0, 0, 0, 0, "R2 zero count");
        step(1, 5,   100, 0, 0, 0, 0, "R2 small count big ceiling");
        step(1, 64'hFFFF_FFFF_FFFF_FF00, 127, 0, 0, 0, 0, "R2 ceiling clamp");
        step(0, 0, 0, 1, 0, 0,    0, "R4 reg zero");
        step(0, 0, 0, 1, 0, 1000, 0, "R4 reg above max");
        step(0, 0, 0, 1, 0, 130,  0, "R4 reg wrap trap");
        step(0, 0, 0, 1, 0, 20,   0, "R4 reg in range");
        step(0, 0, 0, 1, 0, 33,   0, "R6 just above XLEN");
        step(0, 0, 0, 1, 0, 32,   0, "R6 equal XLEN");
        step(0, 0, 0, 1, 1, 0, 0,  "R5 imm zero");
        step(0, 0, 0, 1, 1, 0, 31, "R5 imm max");
        step(0, 0, 0, 1, 1, 99, 7, "R5 imm ignores data");
        step(1, 3, 8, 1, 0, 50, 0, "R7 setvl wins");
        step(1, 0, 8, 1, 1, 0, 9,  "R7 setvl zero wins");
        step(0, 0, 0, 0, 0, 0, 0, "R8 idle");
        step(0, 40, 50, 0, 1, 12, 3, "R8 idle with data");
        step(0, 0, 0, 0, 0, 0, 0, "R8 idle again");

        @(negedge clk);
        setvl_req = 0;
        csr_wr_en = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule